// File: doc/BRIEF.md
# Interrupt Distributor

This block gathers interrupt requests from peripheral lines and from software, keeps per-source enable, pending, active, trigger, priority and routing state, and presents to each CPU one registered candidate: the ID and priority of the best interrupt currently waiting for it. Software programs the block through a word-wide register bus. Every access carries the index of the issuing CPU, and that index picks which private copy of the per-CPU state is seen.

IDs 0 to 15 are raised only by software, through a trigger register that names a set of CPUs and an ID. IDs 16 to 31 are per-CPU peripheral lines. Every CPU has its own enable, pending and active bits for all of IDs 0 to 31. IDs from 32 upward are shared, and a target byte routes each one to any subset of CPUs. Peripheral lines are either rising-edge (pending latches) or level-high (pending follows the line). A single control bit gates all forwarding.

Top module: `irq_dist`

## Requirements
- R1: After reset, the control bit, every enable, pending and active bit, and every priority, target and trigger field are zero. All `cpu_valid` bits are 0 and `bus_rdata` is 0.
- R2: Byte offsets 0x100+4k (set view) and 0x180+4k (clear view) hold the enables of IDs 32k..32k+31, with bit ID%32. Writing 1 to a set-view bit enables that source, and writing 1 to a clear-view bit disables it. Zero bits leave the enable unchanged, and both views read back the current enables.
- R3: Offset 0xC00+4k holds the trigger fields of IDs 16k..16k+15, two bits per ID at bits 2*(ID%16)+1 and 2*(ID%16). A 1 in the upper bit means rising-edge and a 0 means level-high. The lower bit always reads 0. IDs 0..15 always read 2'b10, and writes to their fields are ignored.
- R4: Offset 0x400+4k holds 8-bit priorities for IDs 4k..4k+3, at byte ID%4. They read back as written, for example 0xA0 in every byte.
- R5: Offset 0x800+4k holds 8-bit target bytes for IDs 4k..4k+3, at byte ID%4, where bit n routes the ID to CPU n. For IDs below 32 the byte reads as the one-hot mask of the requesting CPU, and writes to it are ignored.
- R6: Bit 0 at offset 0x000 is the global enable. While it is 0, no `cpu_valid` bit is set.
- R7: The read-only word at offset 0x004 returns NUM_SRC/32-1 in bits 4:0 and 0 in all other bits.
- R8: A write at offset 0xF00 makes the ID in bits 3:0 pending on every CPU n whose bit 16+n is 1, and on no other CPU.
- R9: For IDs 0..31, the enable, pending and active bits exist once per CPU. The bus CPU index of an access picks which copy the access reads or writes.
- R10: The pending views are at 0x200+4k (set) and 0x280+4k (clear), with the same bit layout as R2. An edge source becomes pending on a rising edge of its line, stays pending after the line falls, and clears only through the clear view. A level source is pending exactly while its line is high and it is not active, and pending writes have no effect on it.
- R11: Each CPU is offered the pending, enabled, non-active source with the lowest priority value, taken from IDs 0..31 of its own copy and from shared IDs whose target byte has its bit set. Ties go to the lower ID. The choice appears on the outputs one clock after the state that causes it.
- R12: The active views are at 0x300+4k (set) and 0x380+4k (clear), with the layout of R2 and write-one semantics. A source that is active is never offered to a CPU.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_cpu | input | CPU_W | Index of the CPU issuing the access |
| bus_addr | input | 12 | Byte address; only word-aligned accesses take effect |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after the read |
| irq_in | input | NUM_SRC-16 | Peripheral lines, indexed by ID from 16 upward |
| cpu_valid | output | NUM_CPU | An interrupt is offered to CPU n |
| cpu_id | output | NUM_CPU*ID_W | ID offered to each CPU |
| cpu_prio | output | NUM_CPU*8 | Priority of the offered ID |

## Verification
On every cycle, the assertions check four things. Forwarding stops whenever the global enable is off. A read of the first trigger word always shows the fixed edge pattern of the software IDs. The type word reports the source count. Writes through the set and clear enable views reach a shared source's enable one cycle later. Only the bench's scenarios can show the behaviour that spans several steps: edge latching versus level tracking, masking by the active state, the lowest-value and lowest-ID choice, routing by target byte, per-CPU banking, and software triggers landing only on the CPUs they list.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;
  // Register word indices (byte address >> 2)
  localparam logic [9:0] W_CTRL = 10'h000;
  localparam logic [9:0] W_TYPE = 10'h001;
  localparam logic [9:0] W_ENS  = 10'h040;
  localparam logic [9:0] W_ENC  = 10'h060;
  localparam logic [9:0] W_PDS  = 10'h080;
  localparam logic [9:0] W_PDC  = 10'h0A0;
  localparam logic [9:0] W_ACS  = 10'h0C0;
  localparam logic [9:0] W_ACC  = 10'h0E0;
  localparam logic [9:0] W_PRI  = 10'h100;
  localparam logic [9:0] W_TGT  = 10'h200;
  localparam logic [9:0] W_CFG  = 10'h300;
  localparam logic [9:0] W_SGI  = 10'h3C0;
  localparam int unsigned PRIO_W  = 8;
  localparam int unsigned PRIV_N  = 32;
  localparam int unsigned SOFT_N  = 16;
endpackage

// File: rtl/irq_dist_bank.sv
module irq_dist_bank #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] en_set,
  input  logic [W-1:0] en_clr,
  input  logic [W-1:0] pd_set,
  input  logic [W-1:0] pd_clr,
  input  logic [W-1:0] ac_set,
  input  logic [W-1:0] ac_clr,
  input  logic [W-1:0] is_edge,
  input  logic [W-1:0] lvl_in,
  input  logic [W-1:0] rise,
  output logic [W-1:0] en_q,
  output logic [W-1:0] pd_q,
  output logic [W-1:0] ac_q
);
  logic [W-1:0] ac_d;
  logic [W-1:0] pd_edge_d;

  assign ac_d      = (ac_q | ac_set) & ~ac_clr;
  assign pd_edge_d = (pd_q | rise | pd_set) & ~pd_clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0;
      pd_q <= '0;
      ac_q <= '0;
    end else begin
      en_q <= (en_q | en_set) & ~en_clr;
      ac_q <= ac_d;
      // edge sources latch; level sources follow the line unless active
      pd_q <= (is_edge & pd_edge_d) | (~is_edge & lvl_in & ~ac_d);
    end
  end
endmodule

// File: rtl/irq_dist_arb.sv
module irq_dist_arb #(
  parameter  int unsigned NUM_SRC = 64,
  localparam int unsigned ID_W    = $clog2(NUM_SRC)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 glob_en,
  input  logic [NUM_SRC-1:0]   cand,
  input  logic [NUM_SRC*8-1:0] prio_flat,
  output logic                 out_valid,
  output logic [ID_W-1:0]      out_id,
  output logic [7:0]           out_prio
);
  logic            found;
  logic [ID_W-1:0] best_id;
  logic [7:0]      best_p;

  // linear scan: strict compare keeps the lower ID on equal priority
  always_comb begin
    found   = 1'b0;
    best_id = '0;
    best_p  = 8'hFF;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (cand[i] && (!found || prio_flat[i*8 +: 8] < best_p)) begin
        found   = 1'b1;
        best_id = ID_W'(i);
        best_p  = prio_flat[i*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_id    <= '0;
      out_prio  <= '0;
    end else begin
      out_valid <= glob_en & found;
      out_id    <= (glob_en & found) ? best_id : '0;
      out_prio  <= (glob_en & found) ? best_p  : '0;
    end
  end
endmodule

// File: rtl/irq_dist.sv
module irq_dist
  import irq_dist_pkg::*;
#(
  parameter  int unsigned NUM_SRC = 64,
  parameter  int unsigned NUM_CPU = 4,
  localparam int unsigned ID_W    = $clog2(NUM_SRC),
  localparam int unsigned CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      bus_valid,
  input  logic                      bus_write,
  input  logic [CPU_W-1:0]          bus_cpu,
  input  logic [11:0]               bus_addr,
  input  logic [31:0]               bus_wdata,
  output logic [31:0]               bus_rdata,
  input  logic [NUM_SRC-1:16]       irq_in,
  output logic [NUM_CPU-1:0]        cpu_valid,
  output logic [NUM_CPU*ID_W-1:0]   cpu_id,
  output logic [NUM_CPU*8-1:0]      cpu_prio
);
  localparam int unsigned NWORD = NUM_SRC / 32;
  localparam int unsigned NSH   = NUM_SRC - PRIV_N;
  localparam int unsigned NPRI  = NUM_SRC / 4;
  localparam int unsigned NCFG  = NUM_SRC / 16;

  logic       wr, rd;
  logic [9:0] widx;
  assign widx = bus_addr[11:2];
  assign wr   = bus_valid &  bus_write & (bus_addr[1:0] == 2'b00);
  assign rd   = bus_valid & ~bus_write & (bus_addr[1:0] == 2'b00);

  logic                  glob_en;
  logic [NUM_SRC-1:16]   in_q, rise, cfg_q;
  logic [NUM_SRC-1:0]    cfg_edge;
  logic [7:0]            prio_q [NUM_SRC];
  logic [7:0]            targ_q [NUM_SRC];
  logic [NUM_SRC*8-1:0]  prio_flat;

  assign rise     = irq_in & ~in_q;
  assign cfg_edge = {cfg_q, {SOFT_N{1'b1}}};

  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) prio_flat[i*8 +: 8] = prio_q[i];
  end

  // ---------------- write-one views, decoded to full-width masks ----------
  logic [NUM_SRC-1:0] ens_v, enc_v, pds_v, pdc_v, acs_v, acc_v;
  always_comb begin
    ens_v = '0; enc_v = '0; pds_v = '0; pdc_v = '0; acs_v = '0; acc_v = '0;
    if (wr) begin
      for (int k = 0; k < NWORD; k++) begin
        if (widx == W_ENS + 10'(k)) ens_v[k*32 +: 32] = bus_wdata;
        if (widx == W_ENC + 10'(k)) enc_v[k*32 +: 32] = bus_wdata;
        if (widx == W_PDS + 10'(k)) pds_v[k*32 +: 32] = bus_wdata;
        if (widx == W_PDC + 10'(k)) pdc_v[k*32 +: 32] = bus_wdata;
        if (widx == W_ACS + 10'(k)) acs_v[k*32 +: 32] = bus_wdata;
        if (widx == W_ACC + 10'(k)) acc_v[k*32 +: 32] = bus_wdata;
      end
    end
  end

  // ---------------- control, trigger, priority, target storage -----------
  always_ff @(posedge clk) begin
    if (rst) begin
      glob_en <= 1'b0;
      in_q    <= '0;
      cfg_q   <= '0;
      for (int i = 0; i < NUM_SRC; i++) begin
        prio_q[i] <= '0;
        targ_q[i] <= '0;
      end
    end else begin
      in_q <= irq_in;
      if (wr) begin
        if (widx == W_CTRL) glob_en <= bus_wdata[0];
        for (int k = 0; k < NPRI; k++) begin
          if (widx == W_PRI + 10'(k)) begin
            for (int b = 0; b < 4; b++) prio_q[k*4+b] <= bus_wdata[b*8 +: 8];
          end
          if (widx == W_TGT + 10'(k)) begin
            for (int b = 0; b < 4; b++)
              if (k*4+b >= PRIV_N) targ_q[k*4+b] <= bus_wdata[b*8 +: 8];
          end
        end
        for (int k = 0; k < NCFG; k++) begin
          if (widx == W_CFG + 10'(k)) begin
            for (int j = 0; j < 16; j++)
              if (k*16+j >= SOFT_N) cfg_q[k*16+j] <= bus_wdata[2*j+1];
          end
        end
      end
    end
  end

  // ---------------- shared state for IDs 32 and up -----------------------
  logic [NSH-1:0] en_sh, pd_sh, ac_sh;
  irq_dist_bank #(.W(NSH)) u_shared (
    .clk     (clk),
    .rst     (rst),
    .en_set  (ens_v[NUM_SRC-1:PRIV_N]),
    .en_clr  (enc_v[NUM_SRC-1:PRIV_N]),
    .pd_set  (pds_v[NUM_SRC-1:PRIV_N]),
    .pd_clr  (pdc_v[NUM_SRC-1:PRIV_N]),
    .ac_set  (acs_v[NUM_SRC-1:PRIV_N]),
    .ac_clr  (acc_v[NUM_SRC-1:PRIV_N]),
    .is_edge (cfg_edge[NUM_SRC-1:PRIV_N]),
    .lvl_in  (irq_in[NUM_SRC-1:PRIV_N]),
    .rise    (rise[NUM_SRC-1:PRIV_N]),
    .en_q    (en_sh),
    .pd_q    (pd_sh),
    .ac_q    (ac_sh)
  );

  // ---------------- per-CPU private copies and selection -----------------
  logic [31:0] en_p [NUM_CPU];
  logic [31:0] pd_p [NUM_CPU];
  logic [31:0] ac_p [NUM_CPU];

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic        sel;
    logic [31:0] sgi_v;
    logic [NUM_SRC-1:0] cand;

    assign sel   = (bus_cpu == CPU_W'(c));
    assign sgi_v = (wr && widx == W_SGI && bus_wdata[16+c]) ?
                   (32'd1 << bus_wdata[3:0]) : 32'd0;

    irq_dist_bank #(.W(PRIV_N)) u_priv (
      .clk     (clk),
      .rst     (rst),
      .en_set  (sel ? ens_v[31:0] : 32'd0),
      .en_clr  (sel ? enc_v[31:0] : 32'd0),
      .pd_set  ((sel ? pds_v[31:0] : 32'd0) | sgi_v),
      .pd_clr  (sel ? pdc_v[31:0] : 32'd0),
      .ac_set  (sel ? acs_v[31:0] : 32'd0),
      .ac_clr  (sel ? acc_v[31:0] : 32'd0),
      .is_edge (cfg_edge[31:0]),
      .lvl_in  ({irq_in[31:16], 16'd0}),
      .rise    ({rise[31:16], 16'd0}),
      .en_q    (en_p[c]),
      .pd_q    (pd_p[c]),
      .ac_q    (ac_p[c])
    );

    always_comb begin
      cand[31:0] = en_p[c] & pd_p[c] & ~ac_p[c];
      for (int i = PRIV_N; i < NUM_SRC; i++)
        cand[i] = en_sh[i-PRIV_N] & pd_sh[i-PRIV_N] & ~ac_sh[i-PRIV_N] & targ_q[i][c];
    end

    irq_dist_arb #(.NUM_SRC(NUM_SRC)) u_arb (
      .clk       (clk),
      .rst       (rst),
      .glob_en   (glob_en),
      .cand      (cand),
      .prio_flat (prio_flat),
      .out_valid (cpu_valid[c]),
      .out_id    (cpu_id[c*ID_W +: ID_W]),
      .out_prio  (cpu_prio[c*8 +: 8])
    );
  end

  // ---------------- registered read path ---------------------------------
  logic [NUM_SRC-1:0] en_all, pd_all, ac_all;
  logic [31:0]        rd_mux;
  assign en_all = {en_sh, en_p[bus_cpu]};
  assign pd_all = {pd_sh, pd_p[bus_cpu]};
  assign ac_all = {ac_sh, ac_p[bus_cpu]};

  always_comb begin
    rd_mux = '0;
    if (widx == W_CTRL) rd_mux[0] = glob_en;
    if (widx == W_TYPE) rd_mux[4:0] = 5'(NWORD - 1);
    for (int k = 0; k < NWORD; k++) begin
      if (widx == W_ENS + 10'(k) || widx == W_ENC + 10'(k)) rd_mux = en_all[k*32 +: 32];
      if (widx == W_PDS + 10'(k) || widx == W_PDC + 10'(k)) rd_mux = pd_all[k*32 +: 32];
      if (widx == W_ACS + 10'(k) || widx == W_ACC + 10'(k)) rd_mux = ac_all[k*32 +: 32];
    end
    for (int k = 0; k < NPRI; k++) begin
      if (widx == W_PRI + 10'(k))
        for (int b = 0; b < 4; b++) rd_mux[b*8 +: 8] = prio_q[k*4+b];
      if (widx == W_TGT + 10'(k))
        for (int b = 0; b < 4; b++)
          rd_mux[b*8 +: 8] = (k*4+b < PRIV_N) ? 8'(8'd1 << bus_cpu) : targ_q[k*4+b];
    end
    for (int k = 0; k < NCFG; k++) begin
      if (widx == W_CFG + 10'(k))
        for (int j = 0; j < 16; j++) rd_mux[2*j+1] = cfg_edge[k*16+j];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     bus_rdata <= '0;
    else if (rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/irq_dist_chk.sv
module irq_dist_chk #(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned NUM_CPU = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_valid,
  input logic               bus_write,
  input logic [11:0]        bus_addr,
  input logic               wd0,
  input logic [31:0]        bus_rdata,
  input logic               glob_en,
  input logic [NUM_CPU-1:0] cpu_valid,
  input logic               en32
);
  logic rd_s, wr_s;
  assign rd_s = bus_valid & ~bus_write;
  assign wr_s = bus_valid &  bus_write;

  // R6
  gate_off_chk: assert property (@(posedge clk) disable iff (rst)
    !glob_en |=> (cpu_valid == '0));

  // R3
  soft_cfg_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_s && bus_addr == 12'hC00) |=> (bus_rdata == 32'hAAAA_AAAA));

  // R7
  type_word_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_s && bus_addr == 12'h004) |=> (bus_rdata == 32'(NUM_SRC/32 - 1)));

  // R2
  en_set_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_s && bus_addr == 12'h104 && wd0) |=> en32);

  // R2
  en_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_s && bus_addr == 12'h184 && wd0) |=> !en32);
endmodule

bind irq_dist irq_dist_chk #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_valid (bus_valid),
  .bus_write (bus_write),
  .bus_addr  (bus_addr),
  .wd0       (bus_wdata[0]),
  .bus_rdata (bus_rdata),
  .glob_en   (glob_en),
  .cpu_valid (cpu_valid),
  .en32      (en_sh[0])
);

// File: tb/irq_dist_bench.sv
`timescale 1ns/1ps
module irq_dist_bench;
  localparam int NS = 64;
  localparam int NC = 4;
  localparam int IW = 6;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_valid = 1'b0, bus_write = 1'b0;
  logic [1:0]        bus_cpu = '0;
  logic [11:0]       bus_addr = '0;
  logic [31:0]       bus_wdata = '0, bus_rdata;
  logic [NS-1:16]    irq_in = '0;
  logic [NC-1:0]     cpu_valid;
  logic [NC*IW-1:0]  cpu_id;
  logic [NC*8-1:0]   cpu_prio;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_dist #(.NUM_SRC(NS), .NUM_CPU(NC)) u_irq_dist (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_cpu(bus_cpu), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_in(irq_in), .cpu_valid(cpu_valid),
    .cpu_id(cpu_id), .cpu_prio(cpu_prio)
  );

  typedef struct packed {
    logic        rd;
    logic [1:0]  cpu;
    logic [11:0] addr;
    logic [31:0] data;   // write data, or expected read data
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 2'd0, 12'h104, 32'h0000_0005, 4'd2},  // R2 enable IDs 32,34
    '{1'b1, 2'd0, 12'h104, 32'h0000_0005, 4'd2},  // R2
    '{1'b0, 2'd0, 12'h184, 32'h0000_0004, 4'd2},  // R2 clear ID 34 only
    '{1'b1, 2'd0, 12'h184, 32'h0000_0001, 4'd2},  // R2 clear view reads enables
    '{1'b0, 2'd1, 12'h100, 32'h0001_0002, 4'd9},  // R9 cpu1 private enables
    '{1'b1, 2'd1, 12'h100, 32'h0001_0002, 4'd9},  // R9
    '{1'b1, 2'd0, 12'h100, 32'h0000_0000, 4'd9},  // R9 cpu0 copy untouched
    '{1'b0, 2'd0, 12'hC00, 32'hFFFF_FFFF, 4'd3},  // R3 write to fixed IDs
    '{1'b1, 2'd0, 12'hC00, 32'hAAAA_AAAA, 4'd3},  // R3
    '{1'b0, 2'd0, 12'hC08, 32'h0000_000F, 4'd3},  // R3 IDs 32,33 edge
    '{1'b1, 2'd0, 12'hC08, 32'h0000_000A, 4'd3},  // R3 low bits read 0
    '{1'b0, 2'd0, 12'h420, 32'hA0A0_A0A0, 4'd4},  // R4
    '{1'b1, 2'd0, 12'h420, 32'hA0A0_A0A0, 4'd4},  // R4
    '{1'b0, 2'd0, 12'h820, 32'h0102_0408, 4'd5},  // R5 ID32->cpu3 .. ID35->cpu0
    '{1'b1, 2'd0, 12'h820, 32'h0102_0408, 4'd5},  // R5
    '{1'b1, 2'd2, 12'h800, 32'h0404_0404, 4'd5},  // R5 private targets
    '{1'b1, 2'd0, 12'h004, 32'h0000_0001, 4'd7}   // R7
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] c, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_cpu = c; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] c, input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_cpu = c; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_valid = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] c, input logic [11:0] a,
                        input logic [31:0] exp, input string req);
    logic [31:0] d;
    bus_rd(c, a, d);
    check(d == exp, req, d, exp);
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  // expected {valid, id, prio} for one CPU
  task automatic out_chk(input int c, input bit v, input int id, input int pr,
                         input string req);
    logic [31:0] act, exp;
    act = {16'd0, cpu_valid[c], 1'b0, cpu_id[c*IW +: IW], cpu_prio[c*8 +: 8]};
    exp = {16'd0, v, 1'b0, 6'(id), 8'(pr)};
    check(act == exp, req, act, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(cpu_valid == '0, "R1", 32'(cpu_valid), 32'd0);
    check(bus_rdata == '0, "R1", bus_rdata, 32'd0);
    rd_chk(2'd0, 12'h000, 32'd0, "R1");
    rd_chk(2'd3, 12'h104, 32'd0, "R1");
    rd_chk(2'd0, 12'h404, 32'd0, "R1");

    // table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i].rd) rd_chk(VEC[i].cpu, VEC[i].addr, VEC[i].data,
                            $sformatf("R%0d", VEC[i].req));
      else bus_wr(VEC[i].cpu, VEC[i].addr, VEC[i].data);
    end

    // R6: edge ID32 to cpu3 while global enable is off
    irq_in[32] = 1'b1;
    settle();
    check(cpu_valid == '0, "R6", 32'(cpu_valid), 32'd0);
    bus_wr(2'd0, 12'h000, 32'd1);
    settle();
    out_chk(3, 1, 32, 8'hA0, "R11");
    out_chk(0, 0, 0, 0, "R11");
    irq_in[32] = 1'b0;
    settle();
    out_chk(3, 1, 32, 8'hA0, "R10");

    // R12 active masks the source
    bus_wr(2'd0, 12'h304, 32'd1);
    settle();
    out_chk(3, 0, 0, 0, "R12");
    rd_chk(2'd1, 12'h304, 32'd1, "R12");
    bus_wr(2'd0, 12'h384, 32'd1);
    settle();
    out_chk(3, 1, 32, 8'hA0, "R12");
    bus_wr(2'd0, 12'h284, 32'd1);   // R10 clear edge pending
    settle();
    out_chk(3, 0, 0, 0, "R10");
    rd_chk(2'd0, 12'h204, 32'd0, "R10");

    // level IDs 36,37 routed to cpu0
    bus_wr(2'd0, 12'h824, 32'h0000_0101);
    bus_wr(2'd0, 12'h104, 32'h0000_0030);
    irq_in[36] = 1'b1;
    settle();
    out_chk(0, 1, 36, 0, "R10");
    bus_wr(2'd0, 12'h284, 32'h0000_0010);   // ignored for level source
    settle();
    out_chk(0, 1, 36, 0, "R10");
    irq_in[37] = 1'b1;
    settle();
    out_chk(0, 1, 36, 0, "R11");            // tie -> lower ID
    bus_wr(2'd0, 12'h424, 32'h0000_0040);
    settle();
    out_chk(0, 1, 37, 0, "R11");
    rd_chk(2'd0, 12'h424, 32'h0000_0040, "R4");
    irq_in[37] = 1'b0;
    settle();
    out_chk(0, 1, 36, 8'h40, "R11");
    irq_in[36] = 1'b0;
    settle();
    out_chk(0, 0, 0, 0, "R10");

    // R8 software trigger of ID3 to cpu0 and cpu2
    bus_wr(2'd2, 12'h100, 32'h0000_0008);
    bus_wr(2'd1, 12'hF00, 32'h0005_0003);
    settle();
    out_chk(2, 1, 3, 0, "R8");
    out_chk(1, 0, 0, 0, "R8");
    rd_chk(2'd0, 12'h200, 32'h0000_0008, "R8");
    rd_chk(2'd1, 12'h200, 32'h0000_0000, "R8");

    // R6 global disable stops forwarding
    bus_wr(2'd0, 12'h000, 32'd0);
    settle();
    out_chk(2, 0, 0, 0, "R6");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule